// File: doc/BRIEF.md
# Accumulator and Register Move Unit

This block holds the working registers of a DSP datapath. It has two wide accumulators, each made of a signed extension byte, a high word and a low word. It also has a small bank of 24-bit data registers and a set of 16-bit address registers (pointers, offsets and modifiers). In each instruction slot it accepts an optional full-width result from the arithmetic unit, written into one accumulator. In the same slot it accepts an optional parallel register-to-register transfer, given as a source code and a destination code.

The transfer path converts between register widths and limits a wide accumulator to a word when the extension byte holds significant bits. It refuses a transfer whose destination collides with the accumulator the arithmetic unit is writing in the same slot, and it raises a flag when it does so. A transfer reads the values from before the slot, so it may share its source with the arithmetic operation. Address register updates follow the address logic's pipeline: the value that the address logic sees changes one instruction later than the register file itself.

Top module: `dsp_regmove`

## Requirements
- R1: When an enabled slot has both an arithmetic write to accumulator X and a transfer whose destination is any part of X, `illegal` is high during that slot. The transfer is dropped, and X takes the arithmetic value. A transfer into the other accumulator in that slot is legal.
- R2: A transfer that reads a register the arithmetic unit writes in the same slot gets the value from before the slot and raises no flag.
- R3: A 24-bit source moved into a 16-bit address register stores only its 16 least significant bits.
- R4: A 16-bit address register moved into a 24-bit register fills the low 16 bits and clears the upper 8.
- R5: A full accumulator whose extension is in use, moved into a full accumulator, gives a high word of 24'h7FFFFF when the source is positive (bit 55 = 0) and 24'h800000 when it is negative, a cleared low word, and an extension of 8 copies of the sign. The extension is in use when bits 55 down to 47 are not all equal.
- R6: A full accumulator whose extension is not in use copies all 56 bits to the destination accumulator.
- R7: A 24-bit word moved into a full accumulator lands in the high word, sign-extended into the extension, with the low word cleared.
- R8: After an address register is written by a transfer, `agu_view` keeps the old value until the second enabled slot that follows the write. Transfers read the new value at once.
- R9: With `slot_en` low, no register changes and `illegal` stays low.
- R10: Synchronous active-high reset clears every register.
- R11: The register codes are: 0-3 are the A extension, high, low and full accumulator; 4-7 are the same four for B; 8-11 are data registers D0-D3; 16-21 are address registers 0-5. `alu_dst` is 0 for A and 1 for B. Any other code reads zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| slot_en | input | 1 | Instruction slot valid |
| alu_we | input | 1 | Arithmetic result write request |
| alu_dst | input | 1 | Accumulator written by the arithmetic unit (0 A, 1 B) |
| alu_val | input | 56 | Arithmetic result |
| mv_en | input | 1 | Parallel transfer request |
| mv_src | input | 5 | Transfer source code |
| mv_dst | input | 5 | Transfer destination code |
| obs_sel | input | 2 | Data register shown on `data_obs` |
| agu_sel | input | 3 | Address register shown on `agu_view` |
| illegal | output | 1 | Destination conflict in the current slot |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| data_obs | output | 24 | Selected data register |
| agu_view | output | 16 | Selected address register as the address logic sees it |

## Verification
The hardest case to reach from the ports is a saturating transfer. The source accumulator must hold an extension that is in use, and the same slot must not make the destination collide with the arithmetic write. The random stimulus therefore builds its accumulator values by choosing the extension byte separately, either as a copy of the high word's sign or as a free byte. It also biases the transfer codes toward the full-accumulator codes. The delayed address view is reached by writing address registers and then interleaving idle slots before the enabled slots that advance it.

// File: rtl/dsp_regmove_pkg.sv
`timescale 1ns/1ps
package dsp_regmove_pkg;
  localparam int EXT_W   = 8;
  localparam int WORD_W  = 24;
  localparam int AGU_W   = 16;
  localparam int ACC_W   = EXT_W + 2 * WORD_W;
  localparam int CODE_W  = 5;
  localparam int N_DATA  = 4;
  localparam int N_AGU   = 6;
  localparam int DIDX_W  = $clog2(N_DATA);
  localparam int AIDX_W  = $clog2(N_AGU);
  localparam int HI_LSB  = WORD_W;
  localparam int EXT_LSB = 2 * WORD_W;

  localparam logic [CODE_W-1:0] ACC_END   = CODE_W'(8);
  localparam logic [CODE_W-1:0] DATA_BASE = CODE_W'(8);
  localparam logic [CODE_W-1:0] DATA_END  = CODE_W'(8 + N_DATA);
  localparam logic [CODE_W-1:0] AGU_BASE  = CODE_W'(16);
  localparam logic [CODE_W-1:0] AGU_END   = CODE_W'(16 + N_AGU);

  typedef enum logic [2:0] {K_NONE, K_EXT, K_WORD, K_AGU, K_FULL} kind_e;

  // Extension holds significant bits when it and the high word's sign disagree.
  function automatic logic ext_busy(input logic [ACC_W-1:0] a);
    logic [EXT_W:0] top;
    top = a[ACC_W-1:EXT_LSB-1];
    return !((&top) || !(|top));
  endfunction

  function automatic logic [WORD_W-1:0] sat_word(input logic neg);
    return neg ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
  endfunction

  // Any source reduced to one 24-bit word.
  function automatic logic [WORD_W-1:0] to_word(input kind_e k, input logic [ACC_W-1:0] raw);
    case (k)
      K_EXT:  return {{(WORD_W-EXT_W){raw[EXT_W-1]}}, raw[EXT_W-1:0]};
      K_WORD: return raw[WORD_W-1:0];
      K_AGU:  return {{(WORD_W-AGU_W){1'b0}}, raw[AGU_W-1:0]};
      K_FULL: return ext_busy(raw) ? sat_word(raw[ACC_W-1]) : raw[EXT_LSB-1:HI_LSB];
      default: return '0;
    endcase
  endfunction

  // Any source widened to a full accumulator.
  function automatic logic [ACC_W-1:0] to_full(input kind_e k, input logic [ACC_W-1:0] raw);
    logic [WORD_W-1:0] w;
    if (k == K_FULL) begin
      if (ext_busy(raw))
        return {{EXT_W{raw[ACC_W-1]}}, sat_word(raw[ACC_W-1]), {WORD_W{1'b0}}};
      return raw;
    end
    w = to_word(k, raw);
    return {{EXT_W{w[WORD_W-1]}}, w, {WORD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/dsp_regmove_dec.sv
`timescale 1ns/1ps
module dsp_regmove_dec
  import dsp_regmove_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic              valid,
  output logic              is_acc,
  output logic              acc_sel,
  output logic [1:0]        part,
  output logic              is_data,
  output logic [DIDX_W-1:0] didx,
  output logic              is_agu,
  output logic [AIDX_W-1:0] aidx,
  output kind_e             kind
);
  always_comb begin
    is_acc  = code < ACC_END;
    is_data = (code >= DATA_BASE) && (code < DATA_END);
    is_agu  = (code >= AGU_BASE) && (code < AGU_END);
    valid   = is_acc || is_data || is_agu;
    acc_sel = code[2];
    part    = code[1:0];
    didx    = DIDX_W'(code - DATA_BASE);
    aidx    = AIDX_W'(code - AGU_BASE);
    kind    = K_NONE;
    if (is_acc) begin
      case (part)
        2'd0:    kind = K_EXT;
        2'd3:    kind = K_FULL;
        default: kind = K_WORD;
      endcase
    end else if (is_data) begin
      kind = K_WORD;
    end else if (is_agu) begin
      kind = K_AGU;
    end
  end
endmodule

// File: rtl/dsp_regmove_agu_pipe.sv
`timescale 1ns/1ps
module dsp_regmove_agu_pipe
  import dsp_regmove_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic                         wr,
  input  logic [AIDX_W-1:0]            wr_idx,
  input  logic [AGU_W-1:0]             wr_data,
  output logic [N_AGU-1:0][AGU_W-1:0]  arch,
  output logic [N_AGU-1:0][AGU_W-1:0]  vis,
  output logic                         commit
);
  logic [N_AGU-1:0][AGU_W-1:0] vis_q;
  logic                        pend_v;
  logic [AIDX_W-1:0]           pend_idx;
  logic [AGU_W-1:0]            pend_d;

  assign commit = adv && pend_v;
  assign vis    = vis_q;

  // One pending stage, advanced by each enabled slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v   <= 1'b0;
      pend_idx <= '0;
      pend_d   <= '0;
    end else if (adv) begin
      pend_v   <= wr;
      pend_idx <= wr_idx;
      pend_d   <= wr_data;
    end
  end

  for (genvar g = 0; g < N_AGU; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        vis_q[g] <= '0;
      else if (commit && pend_idx == AIDX_W'(g))
        vis_q[g] <= pend_d;
    end
    assign arch[g] = (pend_v && pend_idx == AIDX_W'(g)) ? pend_d : vis_q[g];
  end
endmodule

// File: rtl/dsp_regmove.sv
`timescale 1ns/1ps
module dsp_regmove
  import dsp_regmove_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_en,
  input  logic              alu_we,
  input  logic              alu_dst,
  input  logic [ACC_W-1:0]  alu_val,
  input  logic              mv_en,
  input  logic [CODE_W-1:0] mv_src,
  input  logic [CODE_W-1:0] mv_dst,
  input  logic [DIDX_W-1:0] obs_sel,
  input  logic [AIDX_W-1:0] agu_sel,
  output logic              illegal,
  output logic [ACC_W-1:0]  acc_a,
  output logic [ACC_W-1:0]  acc_b,
  output logic [WORD_W-1:0] data_obs,
  output logic [AGU_W-1:0]  agu_view
);
  logic [1:0][ACC_W-1:0]        acc_q, acc_nxt;
  logic [N_DATA-1:0][WORD_W-1:0] data_q;
  logic [N_AGU-1:0][AGU_W-1:0]  agu_arch, agu_vis;

  logic s_valid, s_is_acc, s_acc_sel, s_is_data, s_is_agu;
  logic [1:0] s_part;
  logic [DIDX_W-1:0] s_didx;
  logic [AIDX_W-1:0] s_aidx;
  kind_e s_kind;

  logic d_valid, d_is_acc, d_acc_sel, d_is_data, d_is_agu;
  logic [1:0] d_part;
  logic [DIDX_W-1:0] d_didx;
  logic [AIDX_W-1:0] d_aidx;
  kind_e d_kind;

  dsp_regmove_dec u_src_dec (
    .code(mv_src), .valid(s_valid), .is_acc(s_is_acc), .acc_sel(s_acc_sel),
    .part(s_part), .is_data(s_is_data), .didx(s_didx), .is_agu(s_is_agu),
    .aidx(s_aidx), .kind(s_kind)
  );

  dsp_regmove_dec u_dst_dec (
    .code(mv_dst), .valid(d_valid), .is_acc(d_is_acc), .acc_sel(d_acc_sel),
    .part(d_part), .is_data(d_is_data), .didx(d_didx), .is_agu(d_is_agu),
    .aidx(d_aidx), .kind(d_kind)
  );

  // Source read from pre-slot state, zero-padded to accumulator width.
  logic [ACC_W-1:0] src_raw;
  always_comb begin
    src_raw = '0;
    if (s_is_acc) begin
      case (s_part)
        2'd0: src_raw = ACC_W'(acc_q[s_acc_sel][ACC_W-1:EXT_LSB]);
        2'd1: src_raw = ACC_W'(acc_q[s_acc_sel][EXT_LSB-1:HI_LSB]);
        2'd2: src_raw = ACC_W'(acc_q[s_acc_sel][WORD_W-1:0]);
        default: src_raw = acc_q[s_acc_sel];
      endcase
    end else if (s_is_data) begin
      src_raw = ACC_W'(data_q[s_didx]);
    end else if (s_is_agu) begin
      src_raw = ACC_W'(agu_arch[s_aidx]);
    end
  end

  logic [WORD_W-1:0] mv_word;
  logic [ACC_W-1:0]  mv_full;
  assign mv_word = to_word(s_kind, src_raw);
  assign mv_full = to_full(s_kind, src_raw);

  // Named events for the checker.
  logic conflict, mv_go, sat_evt, word_into_full, agu_commit;
  assign conflict       = slot_en && alu_we && mv_en && d_is_acc && (d_acc_sel == alu_dst);
  assign mv_go          = slot_en && mv_en && d_valid && !conflict;
  assign sat_evt        = mv_go && d_kind == K_FULL && s_kind == K_FULL && ext_busy(src_raw);
  assign word_into_full = mv_go && d_kind == K_FULL && s_kind == K_WORD;

  for (genvar g = 0; g < 2; g++) begin : g_acc
    always_comb begin
      acc_nxt[g] = acc_q[g];
      if (alu_we && alu_dst == 1'(g))
        acc_nxt[g] = alu_val;
      if (mv_go && d_is_acc && d_acc_sel == 1'(g)) begin
        case (d_part)
          2'd0: acc_nxt[g][ACC_W-1:EXT_LSB]  = mv_word[EXT_W-1:0];
          2'd1: acc_nxt[g][EXT_LSB-1:HI_LSB] = mv_word;
          2'd2: acc_nxt[g][WORD_W-1:0]       = mv_word;
          default: acc_nxt[g]                = mv_full;
        endcase
      end
    end
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[g] <= '0;
      else if (slot_en)
        acc_q[g] <= acc_nxt[g];
    end
  end

  for (genvar g = 0; g < N_DATA; g++) begin : g_data
    always_ff @(posedge clk) begin
      if (rst)
        data_q[g] <= '0;
      else if (mv_go && d_is_data && d_didx == DIDX_W'(g))
        data_q[g] <= mv_word;
    end
  end

  dsp_regmove_agu_pipe u_agu (
    .clk(clk), .rst(rst), .adv(slot_en), .wr(mv_go && d_is_agu),
    .wr_idx(d_aidx), .wr_data(mv_word[AGU_W-1:0]),
    .arch(agu_arch), .vis(agu_vis), .commit(agu_commit)
  );

  assign illegal  = conflict;
  assign acc_a    = acc_q[0];
  assign acc_b    = acc_q[1];
  assign data_obs = data_q[obs_sel];
  assign agu_view = (32'(agu_sel) < N_AGU) ? agu_vis[agu_sel] : '0;
endmodule

// File: rtl/dsp_regmove_chk.sv
`timescale 1ns/1ps
module dsp_regmove_chk
  import dsp_regmove_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              slot_en,
  input logic              alu_we,
  input logic              alu_dst,
  input logic [ACC_W-1:0]  alu_val,
  input logic              illegal,
  input logic [ACC_W-1:0]  acc_a,
  input logic [ACC_W-1:0]  acc_b,
  input logic              mv_go,
  input logic              sat_evt,
  input logic              word_into_full,
  input logic [CODE_W-1:0] mv_dst
);
  AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !mv_go);  // R1

  AST_ALU_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (($past(alu_dst) ? acc_b : acc_a) == $past(alu_val)));  // R1

  AST_SAT_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (sat_evt && mv_dst == CODE_W'(7)) |=>
      (acc_b[WORD_W-1:0] == '0) && (acc_b[ACC_W-1:EXT_LSB] == {EXT_W{acc_b[EXT_LSB-1]}}) &&
      (acc_b[EXT_LSB-1:HI_LSB] == sat_word(1'b0) || acc_b[EXT_LSB-1:HI_LSB] == sat_word(1'b1)));  // R5

  AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    (word_into_full && mv_dst == CODE_W'(3)) |=>
      (acc_a[WORD_W-1:0] == '0) && (acc_a[ACC_W-1:EXT_LSB] == {EXT_W{acc_a[EXT_LSB-1]}}));  // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> $stable(acc_a) && $stable(acc_b));  // R9

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !slot_en |-> !illegal);  // R9

  AST_FLAG_NEEDS_ALU: assert property (@(posedge clk) disable iff (rst)
    illegal |-> alu_we);  // R1
endmodule

bind dsp_regmove dsp_regmove_chk u_chk (
  .clk(clk), .rst(rst), .slot_en(slot_en), .alu_we(alu_we), .alu_dst(alu_dst),
  .alu_val(alu_val), .illegal(illegal), .acc_a(acc_a), .acc_b(acc_b),
  .mv_go(mv_go), .sat_evt(sat_evt), .word_into_full(word_into_full), .mv_dst(mv_dst)
);

// File: tb/tb_dsp_regmove.sv
`timescale 1ns/1ps
module tb_dsp_regmove;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_en = 1'b0, alu_we = 1'b0, alu_dst = 1'b0, mv_en = 1'b0;
  logic [55:0] alu_val = '0;
  logic [4:0] mv_src = '0, mv_dst = '0;
  logic [1:0] obs_sel = '0;
  logic [2:0] agu_sel = '0;
  logic illegal;
  logic [55:0] acc_a, acc_b;
  logic [23:0] data_obs;
  logic [15:0] agu_view;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dsp_regmove dut (
    .clk(clk), .rst(rst), .slot_en(slot_en), .alu_we(alu_we), .alu_dst(alu_dst),
    .alu_val(alu_val), .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst),
    .obs_sel(obs_sel), .agu_sel(agu_sel), .illegal(illegal), .acc_a(acc_a),
    .acc_b(acc_b), .data_obs(data_obs), .agu_view(agu_view)
  );

  // Reference state
  logic [55:0] m_acc [2];
  logic [23:0] m_dat [4];
  logic [15:0] m_arch [6];
  logic [15:0] m_vis [6];
  int          m_pend = -1;
  logic [15:0] m_pend_d;

  task automatic chk(input string tag, input string what, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit busy(input logic [55:0] r);
    return (r[55:47] != 9'h000) && (r[55:47] != 9'h1ff);
  endfunction

  function automatic logic [23:0] as_word(input int w, input logic [55:0] r);
    if (w == 8)  return {{16{r[7]}}, r[7:0]};
    if (w == 16) return {8'h00, r[15:0]};
    if (w == 24) return r[23:0];
    if (w == 56) return busy(r) ? (r[55] ? 24'h800000 : 24'h7fffff) : r[47:24];
    return 24'h0;
  endfunction

  function automatic logic [55:0] as_full(input int w, input logic [55:0] r);
    logic [23:0] v;
    if (w == 56) return busy(r) ? {{8{r[55]}}, (r[55] ? 24'h800000 : 24'h7fffff), 24'h0} : r;
    v = as_word(w, r);
    return {{8{v[23]}}, v, 24'h0};
  endfunction

  task automatic model(input bit en, input bit we, input bit ds, input logic [55:0] av,
                       input bit me, input logic [4:0] s, input logic [4:0] d);
    int w;
    logic [55:0] r;
    logic [23:0] v;
    bit clash;
    if (!en) return;
    w = 0; r = '0;
    if (s < 8) begin
      case (s % 4)
        0: begin w = 8;  r = {48'h0, m_acc[s/4][55:48]}; end
        1: begin w = 24; r = {32'h0, m_acc[s/4][47:24]}; end
        2: begin w = 24; r = {32'h0, m_acc[s/4][23:0]}; end
        default: begin w = 56; r = m_acc[s/4]; end
      endcase
    end else if (s >= 8 && s < 12) begin
      w = 24; r = {32'h0, m_dat[s-8]};
    end else if (s >= 16 && s < 22) begin
      w = 16; r = {40'h0, m_arch[s-16]};
    end
    v = as_word(w, r);
    clash = we && me && (d < 8) && ((d / 4) == ds);
    if (we) m_acc[ds] = av;
    if (m_pend >= 0) m_vis[m_pend] = m_pend_d;
    m_pend = -1;
    if (me && !clash) begin
      if (d < 8) begin
        case (d % 4)
          0: m_acc[d/4][55:48] = v[7:0];
          1: m_acc[d/4][47:24] = v;
          2: m_acc[d/4][23:0]  = v;
          default: m_acc[d/4]  = as_full(w, r);
        endcase
      end else if (d >= 8 && d < 12) begin
        m_dat[d-8] = v;
      end else if (d >= 16 && d < 22) begin
        m_arch[d-16] = v[15:0];
        m_pend = d - 16;
        m_pend_d = v[15:0];
      end
    end
  endtask

  // Drives one slot 1 ns after an edge, checks the flag mid-slot and state after the edge.
  task automatic slot(input string tag, input bit en, input bit we, input bit ds, input logic [55:0] av,
                      input bit me, input logic [4:0] s, input logic [4:0] d,
                      input logic [1:0] os, input logic [2:0] as);
    bit exp_ill;
    slot_en = en; alu_we = we; alu_dst = ds; alu_val = av;
    mv_en = me; mv_src = s; mv_dst = d; obs_sel = os; agu_sel = as;
    #1;
    exp_ill = en && we && me && (d < 8) && ((d / 4) == ds);
    chk(tag, "illegal", {55'h0, illegal}, {55'h0, exp_ill});
    model(en, we, ds, av, me, s, d);
    @(posedge clk); #1;
    chk(tag, "acc_a", acc_a, m_acc[0]);
    chk(tag, "acc_b", acc_b, m_acc[1]);
    chk(tag, "data_obs", {32'h0, data_obs}, {32'h0, m_dat[os]});
    chk(tag, "agu_view", {40'h0, agu_view}, {40'h0, (as < 6) ? m_vis[as] : 16'h0});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [55:0] keep;
    void'($urandom(32'd2024));
    for (int i = 0; i < 2; i++) m_acc[i] = '0;
    for (int i = 0; i < 4; i++) m_dat[i] = '0;
    for (int i = 0; i < 6; i++) begin m_arch[i] = '0; m_vis[i] = '0; end

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10: every register clear after reset
    for (int i = 0; i < 6; i++) slot("R10", 1'b0, 1'b0, 1'b0, '0, 1'b0, 5'd0, 5'd0, 2'(i % 4), 3'(i));

    // R11: code map, load A then move its high word into D0
    slot("R11", 1, 1, 0, 56'h00_123456_abcdef, 0, 5'd0, 5'd0, 2'd0, 3'd0);
    slot("R11", 1, 0, 0, '0, 1, 5'd1, 5'd8, 2'd0, 3'd0);
    chk("R11", "D0 from A high", {32'h0, data_obs}, 56'h123456);

    // R3 and R8: 24-bit into address register, view lags
    slot("R3", 1, 0, 0, '0, 1, 5'd8, 5'd16, 2'd0, 3'd0);
    chk("R8", "view still old", {40'h0, agu_view}, 56'h0);
    slot("R4", 1, 0, 0, '0, 1, 5'd16, 5'd9, 2'd1, 3'd0);
    chk("R4", "D1 zero-extended", {32'h0, data_obs}, 56'h003456);
    chk("R8", "view updated", {40'h0, agu_view}, 56'h3456);

    // R8 with idle slots between
    slot("R8", 1, 0, 0, '0, 1, 5'd2, 5'd17, 2'd0, 3'd1);
    slot("R8", 0, 0, 0, '0, 0, 5'd0, 5'd0, 2'd0, 3'd1);
    slot("R8", 0, 0, 0, '0, 0, 5'd0, 5'd0, 2'd0, 3'd1);
    chk("R8", "view old across idle", {40'h0, agu_view}, 56'h0);
    slot("R8", 1, 0, 0, '0, 0, 5'd0, 5'd0, 2'd0, 3'd1);
    chk("R8", "view after second slot", {40'h0, agu_view}, 56'hcdef);

    // R5: saturation both signs
    slot("R5", 1, 1, 0, 56'h05_000000_000000, 0, 5'd0, 5'd0, 2'd0, 3'd0);
    slot("R5", 1, 0, 0, '0, 1, 5'd3, 5'd7, 2'd0, 3'd0);
    chk("R5", "positive limit", acc_b, 56'h00_7fffff_000000);
    slot("R5", 1, 1, 0, 56'hf0_123456_789abc, 0, 5'd0, 5'd0, 2'd0, 3'd0);
    slot("R5", 1, 0, 0, '0, 1, 5'd3, 5'd7, 2'd0, 3'd0);
    chk("R5", "negative limit", acc_b, 56'hff_800000_000000);

    // R6: plain copy
    slot("R6", 1, 1, 0, 56'hff_812345_000111, 0, 5'd0, 5'd0, 2'd0, 3'd0);
    slot("R6", 1, 0, 0, '0, 1, 5'd3, 5'd7, 2'd0, 3'd0);
    chk("R6", "full copy", acc_b, 56'hff_812345_000111);

    // R7: word into full accumulator
    slot("R7", 1, 0, 0, '0, 1, 5'd1, 5'd7, 2'd0, 3'd0);
    chk("R7", "negative word", acc_b, 56'hff_812345_000000);
    slot("R7", 1, 0, 0, '0, 1, 5'd8, 5'd3, 2'd0, 3'd0);
    chk("R7", "positive word", acc_a, 56'h00_123456_000000);

    // R1: conflicts and the legal other-accumulator case
    slot("R1", 1, 1, 0, 56'h11_222222_333333, 1, 5'd8, 5'd2, 2'd0, 3'd0);
    chk("R1", "A keeps ALU value", acc_a, 56'h11_222222_333333);
    slot("R1", 1, 1, 1, 56'h01_020304_050607, 1, 5'd8, 5'd4, 2'd0, 3'd0);
    chk("R1", "B keeps ALU value", acc_b, 56'h01_020304_050607);
    slot("R1", 1, 1, 0, 56'h00_000001_000002, 1, 5'd8, 5'd5, 2'd0, 3'd0);
    chk("R1", "other acc written", acc_b[47:24], 56'h123456);

    // R2: shared source reads old value
    keep = acc_a;
    slot("R2", 1, 1, 0, 56'h00_abcdef_000000, 1, 5'd1, 5'd10, 2'd2, 3'd0);
    chk("R2", "D2 holds pre-slot word", {32'h0, data_obs}, {32'h0, keep[47:24]});

    // R9: disabled slot has no effect
    keep = acc_a;
    slot("R9", 0, 1, 0, 56'hde_adbeef_cafe00, 1, 5'd3, 5'd7, 2'd2, 3'd1);
    chk("R9", "A unchanged", acc_a, keep);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [55:0] v;
      logic [4:0] s, d;
      v = {$urandom, $urandom} & 56'hff_ffffff_ffffff;
      if ($urandom % 2) v[55:48] = {8{v[47]}};
      s = ($urandom % 3 == 0) ? (($urandom % 2) ? 5'd3 : 5'd7) : 5'($urandom % 24);
      d = ($urandom % 3 == 0) ? (($urandom % 2) ? 5'd3 : 5'd7) : 5'($urandom % 24);
      slot("RND", ($urandom % 10) != 0, ($urandom % 2) == 1, 1'($urandom), v,
           ($urandom % 4) != 0, s, d, 2'($urandom), 3'($urandom % 8));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule